// File: doc/BRIEF.md
# Interleaved Banked Memory Front End

This block sits between a single vector load/store port and a memory that is split into `NUM_BANKS` independent banks. The low bits of each word address pick the bank and the remaining bits pick the row inside it, so consecutive words fall in consecutive banks. Each bank can hold only one access at a time. Its busy time in clocks is fixed, and the block derives it from the memory cycle time and the clock period.

The port presents at most one request per cycle. If the bank it targets is still busy, `req_ready` drops and the requester holds the request until the bank frees up. A request to a free bank is accepted in the same cycle, even when other banks still have accesses in flight. A read returns its word a fixed number of cycles after it is accepted, marked by a one-cycle `rsp_valid` strobe. Responses therefore come back in the order the reads were accepted. A write updates the bank, keeps that bank busy for the full access time, and returns no response.

Top module: `ilv_mem_front`

## Requirements
- R1: Word address k maps to bank k mod NUM_BANKS, given by the low log2(NUM_BANKS) address bits, and to row k / NUM_BANKS, given by the upper bits. A read of word k returns the last value written to word k.
- R2: A request whose target bank accepted an access less than L cycles earlier sees `req_ready` low. It is not accepted, and it stays pending while the requester holds it.
- R3: The bank busy time is L = ceil(MEM_CYCLE_PS / CLK_PERIOD_PS) clocks, which is 4 with the defaults. A bank accepts again exactly L cycles after its previous acceptance.
- R4: Requests to distinct free banks are accepted in consecutive cycles. With NUM_BANKS >= L, a unit-stride stream is accepted every cycle with no stall.
- R5: A read accepted in cycle t raises `rsp_valid` for exactly one cycle, in cycle t+L, with the word on `rsp_rdata`.
- R6: Read responses appear in the order the reads were accepted, even when those reads went to different banks.
- R7: A write stores its data, never raises `rsp_valid`, and keeps its bank busy for L cycles, the same as a read.
- R8: A synchronous active-high reset clears `rsp_valid`, marks every bank free, and drops any reads still in flight.
- R9: While `req_valid` is low, nothing is accepted and no response is produced for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Target bank is free; the request is accepted when req_valid is also high |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The stimulus revisits one bank at stride NUM_BANKS and at stride 2. This checks that the stall lasts exactly L-1 cycles. An off-by-one busy counter would either accept one cycle early or add an extra stall cycle. A unit-stride stream interleaved with other banks must run without bubbles, which catches a design that stalls globally instead of per bank. A write followed by a read to the same word checks that the write occupies its bank and produces no strobe. A reset issued while a read is in flight must drop that response and free the bank, so a design that leaves its response pipe or busy counters uncleared shows a stray strobe or a false stall.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // integer ceiling division used to turn a memory cycle time into clocks
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROWS   = 256,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc,
  input  logic                    we,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    busy,
  output logic [DATA_W-1:0]       rdata
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem [ROWS];
  logic [CNT_W-1:0]  remain;

  // storage: single port, registered read, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (acc) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end

  // occupancy: loaded with LAT-1 on accept, free again LAT clocks later
  always_ff @(posedge clk) begin
    if (rst)                   remain <= '0;
    else if (acc)              remain <= CNT_W'(LAT - 1);
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/ilv_rsp_pipe.sv
module ilv_rsp_pipe #(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DEPTH-1:0]  v_sr;
  logic [DATA_W-1:0] d_sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sr <= '0;
    end else begin
      v_sr[0] <= in_valid;
      for (int k = 1; k < DEPTH; k++) v_sr[k] <= v_sr[k-1];
    end
  end

  always_ff @(posedge clk) begin
    d_sr[0] <= in_data;
    for (int k = 1; k < DEPTH; k++) d_sr[k] <= d_sr[k-1];
  end

  assign out_valid = v_sr[DEPTH-1];
  assign out_data  = d_sr[DEPTH-1];
endmodule

// File: rtl/ilv_mem_front.sv
module ilv_mem_front #(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 16,
  parameter int NUM_BANKS     = 4,     // power of two, 2..16
  parameter int MEM_CYCLE_PS  = 7500,
  parameter int CLK_PERIOD_PS = 2000   // ratio must round up to at least 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  import ilv_pkg::*;

  localparam int BANK_LAT = int'(ceil_div(MEM_CYCLE_PS, CLK_PERIOD_PS));
  localparam int BSEL_W   = $clog2(NUM_BANKS);
  localparam int ROW_W    = ADDR_W - BSEL_W;
  localparam int ROWS     = 1 << ROW_W;

  logic [BSEL_W-1:0] bank_sel;
  logic [ROW_W-1:0]  bank_row;
  logic              accept;
  logic [NUM_BANKS-1:0] busy_vec;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic [BSEL_W-1:0] rd_sel_q;
  logic              rd_v_q;
  logic [DATA_W-1:0] rd_mux;

  // low bits pick the bank, the rest pick the row
  assign bank_sel  = req_addr[BSEL_W-1:0];
  assign bank_row  = req_addr[ADDR_W-1:BSEL_W];
  assign req_ready = ~busy_vec[bank_sel];
  assign accept    = req_valid & req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .ROWS  (ROWS),
      .DATA_W(DATA_W),
      .LAT   (BANK_LAT)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .acc  (accept && (bank_sel == BSEL_W'(b))),
      .we   (req_write),
      .row  (bank_row),
      .wdata(req_wdata),
      .busy (busy_vec[b]),
      .rdata(bank_rd[b])
    );
  end

  // first response stage runs beside the bank read register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v_q   <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      rd_v_q <= accept & ~req_write;
      if (accept) rd_sel_q <= bank_sel;
    end
  end

  assign rd_mux = bank_rd[rd_sel_q];

  // remaining L-1 stages give a fixed latency, hence in-order return
  ilv_rsp_pipe #(
    .DEPTH (BANK_LAT - 1),
    .DATA_W(DATA_W)
  ) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rd_v_q),
    .in_data  (rd_mux),
    .out_valid(rsp_valid),
    .out_data (rsp_rdata)
  );
endmodule

// File: rtl/ilv_mem_front_chk.sv
module ilv_mem_front_chk #(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 4,
  parameter int BANK_LAT  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid
);
  localparam int BSEL_W = $clog2(NUM_BANKS);
  localparam int IDLE_W = $clog2(BANK_LAT + 1);

  logic [BANK_LAT-1:0] rd_hist;
  logic [IDLE_W-1:0]   since_acc;
  logic                acc;

  assign acc = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hist   <= '0;
      since_acc <= IDLE_W'(BANK_LAT - 1);
    end else begin
      rd_hist[0] <= acc & ~req_write;
      for (int k = 1; k < BANK_LAT; k++) rd_hist[k] <= rd_hist[k-1];
      if (acc)                                   since_acc <= '0;
      else if (since_acc != IDLE_W'(BANK_LAT-1)) since_acc <= since_acc + 1'b1;
    end
  end

  // R8: reset leaves no strobe and every bank free
  a_r8_reset_idle: assert property (@(posedge clk) rst |=> (!rsp_valid && req_ready));

  // R5 / R7: a strobe exactly L cycles after each read accept and never otherwise
  a_r5_rsp_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == rd_hist[BANK_LAT-1]);

  // R2: the bank just accepted is busy on the following cycle
  a_r2_same_bank_stall: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc) && req_valid &&
     req_addr[BSEL_W-1:0] == $past(req_addr[BSEL_W-1:0])) |-> !req_ready);

  // R3: L-1 quiet cycles after the last accept frees every bank
  a_r3_bank_freed: assert property (@(posedge clk) disable iff (rst)
    (since_acc == IDLE_W'(BANK_LAT - 1)) |-> req_ready);
endmodule

bind ilv_mem_front ilv_mem_front_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_BANKS(NUM_BANKS),
  .BANK_LAT (BANK_LAT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid)
);

// File: tb/ilv_mem_front_bench.sv
module ilv_mem_front_bench;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int L  = (7500 + 2000 - 1) / 2000;  // R3: ceil(7500/2000) = 4
  localparam int NROWS = 33;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write, req_ready, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata;

  always #10 clk = ~clk;  // 50 MHz

  ilv_mem_front u_ilv_mem_front (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // row = {valid, write, addr[9:0], wdata[15:0], expected_ready}
  localparam logic [28:0] TBL [NROWS] = '{
    {1'b1,1'b1,10'd0,16'h0100,1'b1}, {1'b1,1'b1,10'd1,16'h0101,1'b1},
    {1'b1,1'b1,10'd2,16'h0102,1'b1}, {1'b1,1'b1,10'd3,16'h0103,1'b1},
    {1'b1,1'b1,10'd4,16'h0104,1'b1}, {1'b1,1'b1,10'd5,16'h0105,1'b1},
    {1'b1,1'b1,10'd6,16'h0106,1'b1}, {1'b1,1'b1,10'd7,16'h0107,1'b1},
    {1'b1,1'b0,10'd0,16'h0,1'b1},    {1'b1,1'b0,10'd1,16'h0,1'b1},
    {1'b1,1'b0,10'd2,16'h0,1'b1},    {1'b1,1'b0,10'd3,16'h0,1'b1},
    {1'b1,1'b0,10'd4,16'h0,1'b1},    {1'b1,1'b0,10'd5,16'h0,1'b1},
    {1'b1,1'b0,10'd6,16'h0,1'b1},    {1'b1,1'b0,10'd7,16'h0,1'b1},
    {1'b1,1'b0,10'd0,16'h0,1'b1},    {1'b1,1'b0,10'd4,16'h0,1'b0},
    {1'b1,1'b0,10'd4,16'h0,1'b0},    {1'b1,1'b0,10'd4,16'h0,1'b0},
    {1'b1,1'b0,10'd4,16'h0,1'b1},    {1'b1,1'b0,10'd2,16'h0,1'b1},
    {1'b1,1'b0,10'd1,16'h0,1'b1},    {1'b1,1'b0,10'd3,16'h0,1'b1},
    {1'b1,1'b0,10'd5,16'h0,1'b0},    {1'b1,1'b0,10'd5,16'h0,1'b0},
    {1'b1,1'b0,10'd5,16'h0,1'b1},    {1'b0,1'b0,10'd0,16'h0,1'b1},
    {1'b1,1'b1,10'd6,16'h02AA,1'b1}, {1'b1,1'b0,10'd6,16'h0,1'b0},
    {1'b1,1'b0,10'd6,16'h0,1'b0},    {1'b1,1'b0,10'd6,16'h0,1'b0},
    {1'b1,1'b0,10'd6,16'h0,1'b1}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] model [1024];
  logic          exp_v [64];
  logic [DW-1:0] exp_d [64];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R8: state out of reset
    check(rsp_valid == 1'b0, "R8 rsp_valid after reset", 32'(rsp_valid), 0);
    check(req_ready == 1'b1, "R8 banks free after reset", 32'(req_ready), 1);

    for (int i = 0; i < NROWS + L + 2; i++) begin
      logic [28:0] row;
      @(negedge clk);
      // R5/R6/R7/R9: strobe and data for this cycle
      check(rsp_valid === exp_v[i], "R5/R7/R9 rsp_valid timing", 32'(rsp_valid), 32'(exp_v[i]));
      if (exp_v[i] && rsp_valid)
        check(rsp_rdata === exp_d[i], "R1/R6 rsp_rdata order and value", 32'(rsp_rdata), 32'(exp_d[i]));
      row = (i < NROWS) ? TBL[i] : 29'd0;
      req_valid = row[28]; req_write = row[27];
      req_addr  = row[26:17]; req_wdata = row[16:1];
      #1;
      if (row[28]) begin
        // R2/R3/R4: ready follows per-bank occupancy
        check(req_ready === row[0], "R2/R3/R4 req_ready", 32'(req_ready), 32'(row[0]));
        if (row[0]) begin
          if (row[27]) model[row[26:17]] = row[16:1];
          else begin
            exp_v[i + L] = 1'b1;
            exp_d[i + L] = model[row[26:17]];
          end
        end
      end
    end

    // R8: reset while a read is in flight
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'd3;
    #1;
    check(req_ready == 1'b1, "R4 free bank ready", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(req_ready == 1'b1, "R8 busy bank freed by reset", 32'(req_ready), 1);
    for (int k = 0; k < L + 1; k++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R8 in-flight read dropped", 32'(rsp_valid), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule